// File: doc/BRIEF.md
# Gated Prescaled Compare Timer

This block is one channel of a general-purpose 16-bit up-counter, placed behind a simple word-wide register port. Software loads a starting count and a compare value, then writes a single mode word. That word picks what advances the counter: every bus clock, one in every 16 or 256 bus clocks, or each rising edge of an external horizontal-blank pulse. It also picks whether a blanking signal gates the count, and which one.

When gating is on, the chosen blank signal either pauses the count while it is high (level mode), or zeroes the count on a selected edge (edge modes) and counting then resumes. A match against the compare value sets an equal flag and can optionally return the count to zero. Rolling past the top value sets an overflow flag. Both flags are cleared by writing one to them, and each flag has its own enable onto the interrupt line. An external capture pulse copies the live count into a hold register.

The register port sees one channel only. Channel placement and address translation belong to the surrounding bus fabric.

Top module: `gated_compare_timer`

## Requirements
- R1: After reset, the count, mode, compare and hold registers all read 0 and irqOut is low.
- R2: addr[5:4] selects the register: 0 count, 1 mode, 2 compare, 3 hold. Count, compare and hold read back zero-extended from 16 bits to 32. A count write loads wrData[15:0] directly. A mode write stores bits 9:0.
- R3: Mode bit 7 enables counting. While bit 7 is clear the count holds its value. Mode bits 1:0 pick the tick: 0 every bus clock, 1 once per 16 bus clocks, 2 once per 256 bus clocks, 3 once per rising edge of hBlankIn.
- R4: Mode bit 2 enables gating, and mode bit 3 picks the gate signal (0 hBlankIn, 1 vBlankIn). With gate mode 0 (bits 5:4 = 0), ticks are taken only while the gate signal is low.
- R5: In gate modes 1, 2 and 3, the count goes to 0 on the gate's rising edge, falling edge, or either edge respectively, and counting continues afterwards. Blank inputs pass through a 2-stage synchronizer, so the clear lands on the third clock edge after the input changes.
- R6: A tick taken while the count equals the compare value sets the equal flag (mode bit 10). If zero-return (mode bit 6) is set, that tick loads 0 instead of count+1.
- R7: A tick taken at count 0xFFFF sets the overflow flag (mode bit 11), and the count becomes 0.
- R8: Writing 1 to mode bit 10 or bit 11 clears that flag. Writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: irqOut is high exactly when (bit 10 and bit 8) or (bit 11 and bit 9) are set in the mode register.
- R10: A one-cycle captureEvt pulse copies the current count into the hold register. Without a pulse, the hold value does not change.
- R11: A software count write takes priority over a gate-edge clear, and a gate-edge clear takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset within the channel |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| hBlankIn | input | 1 | Asynchronous horizontal-blank signal |
| vBlankIn | input | 1 | Asynchronous vertical-blank signal |
| captureEvt | input | 1 | Synchronous capture pulse for the hold register |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, divide-by-16 and divide-by-256 prescalers, a two-stage synchronizer and the hold register present. Because the count is only 16 bits wide, the 0xFFFF wrap can be reached from a preloaded value in a few cycles. Because the prescaler divides are small, both divided tick rates can be measured as exact count deltas over whole multiples of their periods. The two-stage synchronizer fixes the gate-clear timing at a known edge, which lets the bench line a software count write up against a gate clear in the same cycle.

// File: rtl/gct_pkg.sv
package gct_pkg;

  // Strobes from control to datapath, one per cycle.
  typedef struct packed {
    logic tick;     // advance the count
    logic gateClr;  // gate edge: return count to zero
    logic loadCnt;  // software write to count
    logic loadCmp;  // software write to compare
    logic capture;  // copy count into hold
  } strobe_t;

  localparam logic [1:0] SEL_COUNT = 2'd0;
  localparam logic [1:0] SEL_MODE  = 2'd1;
  localparam logic [1:0] SEL_COMP  = 2'd2;
  localparam logic [1:0] SEL_HOLD  = 2'd3;

  typedef enum logic [1:0] {
    SRC_BUS    = 2'd0,
    SRC_DIV_A  = 2'd1,
    SRC_DIV_B  = 2'd2,
    SRC_HBLANK = 2'd3
  } clkSrc_t;

  typedef enum logic [1:0] {
    GATE_LOW  = 2'd0,
    GATE_RISE = 2'd1,
    GATE_FALL = 2'd2,
    GATE_BOTH = 2'd3
  } gateMode_t;

endpackage

// File: rtl/gct_sync.sv
module gct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= '0;
    else begin
      stg[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign syncOut = stg[STAGES-1];
endmodule

// File: rtl/gct_ctrl.sv
module gct_ctrl
  import gct_pkg::*;
#(
  parameter int DIV_A_LOG   = 4,
  parameter int DIV_B_LOG   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  regSel,
  input  logic [11:0] wrBits,
  input  logic        hBlankIn,
  input  logic        vBlankIn,
  input  logic        captureEvt,
  input  logic        eqHit,
  input  logic        wrapHit,
  output strobe_t     stb,
  output logic [11:0] modeWord,
  output logic        zeroRet,
  output logic        irqOut
);
  logic [1:0] clkSel;
  gateMode_t  gateMode;
  logic gateEn, gateSel, cntEn, cmpIe, ovfIe, eqFlag, ovFlag;

  logic modeWr;
  assign modeWr = wrEn && regSel == SEL_MODE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel <= '0; gateEn <= 1'b0; gateSel <= 1'b0; gateMode <= GATE_LOW;
      zeroRet <= 1'b0; cntEn <= 1'b0; cmpIe <= 1'b0; ovfIe <= 1'b0;
    end else if (modeWr) begin
      clkSel   <= wrBits[1:0];
      gateEn   <= wrBits[2];
      gateSel  <= wrBits[3];
      gateMode <= gateMode_t'(wrBits[5:4]);
      zeroRet  <= wrBits[6];
      cntEn    <= wrBits[7];
      cmpIe    <= wrBits[8];
      ovfIe    <= wrBits[9];
    end
  end

  // Status flags: hardware set wins over a write-one clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eqFlag <= 1'b0; ovFlag <= 1'b0;
    end else begin
      eqFlag <= eqHit   | (eqFlag & ~(modeWr & wrBits[10]));
      ovFlag <= wrapHit | (ovFlag & ~(modeWr & wrBits[11]));
    end
  end

  // Blank inputs: synchronize, then keep the previous value for edges.
  logic [1:0] blankSync, blankPrev;
  gct_sync #(.W(2), .STAGES(SYNC_STAGES)) i_blankSync (
    .clk(clk), .rstN(rstN), .asyncIn({vBlankIn, hBlankIn}), .syncOut(blankSync)
  );
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blankPrev <= '0;
    else       blankPrev <= blankSync;
  end

  // Free-running prescaler.
  logic [DIV_B_LOG-1:0] preCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  logic divATick, divBTick, hRise, srcTick;
  assign divATick = &preCnt[DIV_A_LOG-1:0];
  assign divBTick = &preCnt;
  assign hRise    = blankSync[0] & ~blankPrev[0];

  always_comb begin
    case (clkSrc_t'(clkSel))
      SRC_BUS:   srcTick = 1'b1;
      SRC_DIV_A: srcTick = divATick;
      SRC_DIV_B: srcTick = divBTick;
      default:   srcTick = hRise;
    endcase
  end

  logic gateNow, gatePrev, gateRise, gateFall, edgeHit, gateOpen;
  assign gateNow  = gateSel ? blankSync[1] : blankSync[0];
  assign gatePrev = gateSel ? blankPrev[1] : blankPrev[0];
  assign gateRise = gateNow & ~gatePrev;
  assign gateFall = ~gateNow & gatePrev;

  always_comb begin
    case (gateMode)
      GATE_RISE: edgeHit = gateRise;
      GATE_FALL: edgeHit = gateFall;
      GATE_BOTH: edgeHit = gateRise | gateFall;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign gateOpen = !gateEn || gateMode != GATE_LOW || !gateNow;

  assign stb.tick    = cntEn & srcTick & gateOpen;
  assign stb.gateClr = cntEn & gateEn & edgeHit;
  assign stb.loadCnt = wrEn && regSel == SEL_COUNT;
  assign stb.loadCmp = wrEn && regSel == SEL_COMP;
  assign stb.capture = captureEvt;

  assign modeWord = {ovFlag, eqFlag, ovfIe, cmpIe, cntEn, zeroRet,
                     gateMode, gateSel, gateEn, clkSel};
  assign irqOut   = (eqFlag & cmpIe) | (ovFlag & ovfIe);

  // R6: a compare hit is visible in the flag on the next cycle
  assert_eq_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    eqHit |=> eqFlag);
  // R8: write-one clears the equal flag when no new hit arrives
  assert_eq_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && wrBits[10] && !eqHit) |=> !eqFlag);
  // R8: overflow flag holds unless a one is written to it
  assert_ov_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovFlag && !(modeWr && wrBits[11])) |=> ovFlag);
  // R4: in level gate mode a high gate blocks every tick
  assert_gate_block_R4: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn && gateMode == GATE_LOW && gateNow) |-> !stb.tick);
endmodule

// File: rtl/gct_datapath.sv
module gct_datapath
  import gct_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit HAS_HOLD = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wrVal,
  input  logic             zeroRet,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] hold,
  output logic             eqHit,
  output logic             wrapHit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic stepTaken;
  assign stepTaken = stb.tick & ~stb.loadCnt & ~stb.gateClr;
  assign eqHit     = stepTaken && count == compare;
  assign wrapHit   = stepTaken && count == CNT_MAX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '0;
    else if (stb.loadCnt)      count <= wrVal;
    else if (stb.gateClr)      count <= '0;
    else if (stb.tick)         count <= (eqHit && zeroRet) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            compare <= '0;
    else if (stb.loadCmp) compare <= wrVal;
  end

  generate
    if (HAS_HOLD) begin : g_hold
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            hold <= '0;
        else if (stb.capture) hold <= count;
      end
    end else begin : g_noHold
      assign hold = '0;
    end
  endgenerate

  // R2: software write lands in the count
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCnt |=> count == $past(wrVal));
  // R11: gate clear beats a tick but yields to a software write
  assert_clr_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.gateClr && !stb.loadCnt) |=> count == '0);
  // R3: no strobe, no change
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.tick || stb.gateClr || stb.loadCnt) |=> $stable(count));
  // R7: a wrapping step always lands on zero
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit |=> count == '0);
endmodule

// File: rtl/gated_compare_timer.sv
module gated_compare_timer
  import gct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int REG_W       = 32,
  parameter int DIV_A_LOG   = 4,
  parameter int DIV_B_LOG   = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_HOLD    = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [5:0]       addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             hBlankIn,
  input  logic             vBlankIn,
  input  logic             captureEvt,
  output logic             irqOut
);
  localparam int PAD_CNT  = REG_W - CNT_W;
  localparam int PAD_MODE = REG_W - 12;

  logic [1:0]       regSel;
  strobe_t          stb;
  logic [11:0]      modeWord;
  logic             zeroRet, eqHit, wrapHit;
  logic [CNT_W-1:0] count, compare, hold;

  assign regSel = addr[5:4];

  gct_ctrl #(
    .DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrBits(wrData[11:0]),
    .hBlankIn(hBlankIn), .vBlankIn(vBlankIn), .captureEvt(captureEvt),
    .eqHit(eqHit), .wrapHit(wrapHit), .stb(stb), .modeWord(modeWord),
    .zeroRet(zeroRet), .irqOut(irqOut)
  );

  gct_datapath #(.CNT_W(CNT_W), .HAS_HOLD(HAS_HOLD)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrVal(wrData[CNT_W-1:0]),
    .zeroRet(zeroRet), .count(count), .compare(compare), .hold(hold),
    .eqHit(eqHit), .wrapHit(wrapHit)
  );

  always_comb begin
    case (regSel)
      SEL_COUNT: rdData = {{PAD_CNT{1'b0}}, count};
      SEL_MODE:  rdData = {{PAD_MODE{1'b0}}, modeWord};
      SEL_COMP:  rdData = {{PAD_CNT{1'b0}}, compare};
      default:   rdData = {{PAD_CNT{1'b0}}, hold};
    endcase
  end

  logic unusedWr;
  assign unusedWr = ^{wrData[REG_W-1:CNT_W], addr[3:0]};
endmodule

// File: tb/test_gated_compare_timer.sv
module test_gated_compare_timer;
  localparam time CLK_PERIOD = 10;
  localparam logic [5:0] A_CNT = 6'h00, A_MODE = 6'h10, A_CMP = 6'h20, A_HOLD = 6'h30;
  localparam logic [31:0] M_GATE = 32'h4, M_VSEL = 32'h8, M_ZRET = 32'h40,
                          M_CUE = 32'h80, M_CMPE = 32'h100, M_OVFE = 32'h200,
                          M_EQF = 32'h400, M_OVF = 32'h800;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic hBlankIn = 1'b0, vBlankIn = 1'b0, captureEvt = 1'b0, irqOut;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_compare_timer i_gated_compare_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .hBlankIn(hBlankIn), .vBlankIn(vBlankIn),
    .captureEvt(captureEvt), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge.
  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rdReg(A_CNT, v);  check("R1 count", v, 0);
    rdReg(A_MODE, v); check("R1 mode", v, 0);
    rdReg(A_CMP, v);  check("R1 compare", v, 0);
    rdReg(A_HOLD, v); check("R1 hold", v, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wrReg(A_CNT, 32'hABCD1234);
    rdReg(A_CNT, v); check("R2 count zero-extended", v, 32'h1234);
    wrReg(A_CMP, 32'hFFFF5A5A);
    rdReg(A_CMP, v); check("R2 compare zero-extended", v, 32'h5A5A);
    wrReg(A_MODE, 32'hFFFFF36F);
    rdReg(A_MODE, v); check("R2 mode bits 9:0", v, 32'h36F);
    waitEdges(5);
    rdReg(A_CNT, v); check("R3 no count without enable", v, 32'h1234);
    wrReg(A_MODE, 0);
  endtask

  task automatic t_sources;
    logic [31:0] a, b;
    wrReg(A_CNT, 0); wrReg(A_MODE, M_CUE);
    waitEdges(10);
    rdReg(A_CNT, a); check("R3 bus clock source", a, 10);
    wrReg(A_MODE, M_CUE | 1);
    rdReg(A_CNT, a); waitEdges(64); rdReg(A_CNT, b);
    check("R3 divide by 16", b - a, 4);
    wrReg(A_MODE, M_CUE | 2);
    rdReg(A_CNT, a); waitEdges(512); rdReg(A_CNT, b);
    check("R3 divide by 256", b - a, 2);
    wrReg(A_MODE, 0); wrReg(A_CNT, 0); wrReg(A_MODE, M_CUE | 3);
    for (int i = 0; i < 3; i++) begin
      hBlankIn = 1'b1; waitEdges(3); hBlankIn = 1'b0; waitEdges(3);
    end
    waitEdges(6);
    rdReg(A_CNT, a); check("R3 hblank pulse source", a, 3);
    wrReg(A_MODE, 0);
  endtask

  task automatic t_gateLevel;
    logic [31:0] v;
    hBlankIn = 1'b1; waitEdges(4);
    wrReg(A_CNT, 0); wrReg(A_MODE, M_CUE | M_GATE);
    waitEdges(8);
    rdReg(A_CNT, v); check("R4 high gate holds count", v, 0);
    hBlankIn = 1'b0; waitEdges(10);
    rdReg(A_CNT, v); check("R4 low gate counts", v, 8);
    vBlankIn = 1'b1; wrReg(A_MODE, 0); waitEdges(4);
    wrReg(A_CNT, 0); wrReg(A_MODE, M_CUE | M_GATE | M_VSEL);
    waitEdges(8);
    rdReg(A_CNT, v); check("R4 vblank select holds count", v, 0);
    wrReg(A_MODE, 0); vBlankIn = 1'b0; waitEdges(4);
  endtask

  task automatic t_gateEdge;
    logic [31:0] v;
    wrReg(A_CNT, 32'h100); wrReg(A_MODE, M_CUE | M_GATE | (1 << 4));
    waitEdges(5);
    rdReg(A_CNT, v); check("R5 rise mode runs", v, 32'h105);
    hBlankIn = 1'b1; waitEdges(6);
    rdReg(A_CNT, v); check("R5 rise clears", v, 3);
    hBlankIn = 1'b0; waitEdges(4);
    wrReg(A_CNT, 32'h200); wrReg(A_MODE, M_CUE | M_GATE | (2 << 4));
    hBlankIn = 1'b1; waitEdges(6);
    rdReg(A_CNT, v); check("R5 fall mode ignores rise", v, 32'h207);
    hBlankIn = 1'b0; waitEdges(6);
    rdReg(A_CNT, v); check("R5 fall clears", v, 3);
    wrReg(A_CNT, 32'h300); wrReg(A_MODE, M_CUE | M_GATE | M_VSEL | (3 << 4));
    vBlankIn = 1'b1; waitEdges(6);
    rdReg(A_CNT, v); check("R5 both mode rise clears", v, 3);
    waitEdges(4);
    vBlankIn = 1'b0; waitEdges(6);
    rdReg(A_CNT, v); check("R5 both mode fall clears", v, 3);
    wrReg(A_MODE, M_CUE | M_GATE | (1 << 4));
    hBlankIn = 1'b1; waitEdges(2);
    wrReg(A_CNT, 32'h4444);
    rdReg(A_CNT, v); check("R11 write beats gate clear", v, 32'h4444);
    waitEdges(2);
    rdReg(A_CNT, v); check("R11 counting resumes", v, 32'h4446);
    wrReg(A_MODE, 0); hBlankIn = 1'b0; waitEdges(4);
  endtask

  task automatic t_compare;
    logic [31:0] v;
    wrReg(A_MODE, M_EQF | M_OVF);
    wrReg(A_CNT, 0); wrReg(A_CMP, 5); wrReg(A_MODE, M_CUE | M_ZRET | M_CMPE);
    waitEdges(5);
    rdReg(A_MODE, v); check("R6 no flag before match", v & M_EQF, 0);
    check("R9 irq low before match", {31'b0, irqOut}, 0);
    waitEdges(1);
    rdReg(A_CNT, v);  check("R6 zero return", v, 0);
    rdReg(A_MODE, v); check("R6 equal flag set", v & M_EQF, M_EQF);
    check("R9 irq on equal", {31'b0, irqOut}, 1);
    wrReg(A_MODE, M_CMPE | M_EQF);
    rdReg(A_MODE, v); check("R8 write one clears", v & M_EQF, 0);
    check("R9 irq drops", {31'b0, irqOut}, 0);
    wrReg(A_CNT, 3); wrReg(A_MODE, M_CUE | M_CMPE);
    waitEdges(3);
    rdReg(A_CNT, v);  check("R6 no zero return continues", v, 6);
    wrReg(A_MODE, M_CMPE);
    rdReg(A_MODE, v); check("R8 write zero keeps flag", v & M_EQF, M_EQF);
    check("R9 irq stays", {31'b0, irqOut}, 1);
    wrReg(A_MODE, 0);
    check("R9 irq masked", {31'b0, irqOut}, 0);
    wrReg(A_MODE, M_EQF);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wrReg(A_CNT, 32'hFFFD); wrReg(A_CMP, 32'h1234); wrReg(A_MODE, M_CUE | M_OVFE);
    waitEdges(2);
    rdReg(A_MODE, v); check("R7 no flag at top", v & M_OVF, 0);
    waitEdges(1);
    rdReg(A_CNT, v);  check("R7 wrap to zero", v, 0);
    rdReg(A_MODE, v); check("R7 overflow flag", v & M_OVF, M_OVF);
    check("R9 irq on overflow", {31'b0, irqOut}, 1);
    wrReg(A_MODE, M_OVF);
    check("R8 overflow cleared", {31'b0, irqOut}, 0);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wrReg(A_MODE, 0); wrReg(A_CNT, 32'h2468);
    captureEvt = 1'b1; waitEdges(1); captureEvt = 1'b0;
    rdReg(A_HOLD, v); check("R10 capture", v, 32'h2468);
    wrReg(A_CNT, 32'h1111); waitEdges(2);
    rdReg(A_HOLD, v); check("R10 hold kept", v, 32'h2468);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    t_reset();
    t_regmap();
    t_sources();
    t_gateLevel();
    t_gateEdge();
    t_compare();
    t_overflow();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule